// File: doc/BRIEF.md
# High-Speed Burst Lane Sequencer

This block is the transmit side of one serial data lane. It takes a stream of bytes from the protocol layer and sends it as one high-speed burst. From the idle stop state it first drives a fixed low-power request sequence on the two single-ended lines. It then switches to high-speed signalling, sends a fixed sync byte and shifts the payload out one bit per clock, least significant bit first. It closes the burst with a trailer and returns the lines to the stop state.

A burst starts only while the clock lane is in high-speed mode, which the `clk_lane_hs` input signals. The first byte is taken in the stop state and held while the preamble and the sync byte go out. Each later byte is taken in the final bit time of the byte before it. The byte flagged as last, or a missing byte at a byte boundary, ends the payload. Each low-power preamble step and the closing stop hold last `LP_HOLD` cycles, with 1 to 255 allowed. The trailer lasts `TRAIL_BITS` bit times.

Top module: `hs_burst_lane_tx`

## Requirements
- R1: During and after reset, with no burst requested, `lp_drive` is 2'b11 (stop state), `hs_en` is 0 and `hs_bit` is 0.
- R2: In the stop state `in_ready` equals `clk_lane_hs`. A burst begins only in a cycle where `in_valid` and `clk_lane_hs` are both high. With `clk_lane_hs` low the lane stays at 2'b11 whatever `in_valid` does.
- R3: After a burst is accepted, `lp_drive` shows 2'b01 for `LP_HOLD` cycles and then 2'b00 for `LP_HOLD` cycles, with `hs_en` low. Bit 1 of `lp_drive` is the positive line and bit 0 is the negative line.
- R4: `hs_en` then rises, and `hs_bit` carries the sync byte 8'b00011101 over 8 cycles, least significant bit first. `lp_drive` reads 2'b00 whenever `hs_en` is high.
- R5: Payload bytes follow the sync byte directly in the order they were accepted, one bit per cycle, least significant bit first.
- R6: `in_ready` is high only in the stop state (as in R2) and in the final bit time of a payload byte that was not flagged last. It is low in the preamble, the sync byte, the trailer and the stop hold.
- R7: A byte accepted with `in_last` high is the final payload byte of its burst, and the trailer starts in the next cycle.
- R8: The trailer holds `hs_bit` at the inverse of the last payload bit for `TRAIL_BITS` cycles, with `hs_en` high.
- R9: After the trailer, `hs_en` falls and `lp_drive` returns to 2'b11 together with it. The lane stays there for `LP_HOLD` cycles with `in_ready` low, even when `in_valid` is high, before another burst can be accepted.
- R10: If `in_valid` is low in the final bit time of a byte that was not flagged last, that byte ends the payload and the trailer follows.
- R11: `hs_bit` is 0 whenever `hs_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lane_hs | input | 1 | High while the clock lane is in high-speed mode; gates burst start |
| in_valid | input | 1 | Byte offered by the protocol layer |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the last of its burst |
| in_ready | output | 1 | Byte accepted at this clock edge when in_valid is high |
| lp_drive | output | 2 | Low-power line levels {positive, negative} |
| hs_en | output | 1 | High-speed driver enable |
| hs_bit | output | 1 | Serial high-speed data bit |

## Verification
Bursts of one and of three bytes use payloads whose final bits differ, so the trailer polarity is checked both ways. All-zero and all-ones bytes placed next to each other show whether bit order and byte order are kept across a byte boundary. A burst whose source stops offering data without flagging last is compared against one that ends on the last flag, which separates the two ways a burst can end. A second burst whose data is offered during the first burst's trailer checks that nothing is accepted before the stop hold ends. A phase with the clock-lane flag low and data offered checks that the lane does not leave the stop state.

// File: rtl/hs_lane_pkg.sv
`timescale 1ns/1ps
package hs_lane_pkg;

  localparam int LANE_BYTE_W = 8;

  localparam logic [LANE_BYTE_W-1:0] HS_SYNC_WORD = 8'b00011101;

  localparam logic [1:0] LINES_STOP   = 2'b11;
  localparam logic [1:0] LINES_REQ    = 2'b01;
  localparam logic [1:0] LINES_BRIDGE = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LP01  = 3'd1,
    ST_LP00  = 3'd2,
    ST_SYNC  = 3'd3,
    ST_DATA  = 3'd4,
    ST_TRAIL = 3'd5,
    ST_HOLD  = 3'd6
  } lane_state_e;

endpackage

// File: rtl/hs_lane_phase_cnt.sv
`timescale 1ns/1ps
module hs_lane_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == limit);

endmodule

// File: rtl/hs_lane_shifter.sv
`timescale 1ns/1ps
module hs_lane_shifter
  import hs_lane_pkg::*;
#(
  parameter int BYTE_W = LANE_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preload_en,
  input  logic              load_hold_en,
  input  logic              load_in_en,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              ser_bit,
  output logic              cur_last,
  output logic              last_sent
);

  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hold_last_q, hold_last_d;
  logic              cur_last_q, cur_last_d;
  logic              sent_q, sent_d;

  always_comb begin
    shreg_d     = shreg_q;
    hold_d      = hold_q;
    hold_last_d = hold_last_q;
    cur_last_d  = cur_last_q;
    sent_d      = sent_q;
    if (shift_en) begin
      sent_d = shreg_q[0];
    end
    if (preload_en) begin
      shreg_d     = HS_SYNC_WORD;
      hold_d      = in_data;
      hold_last_d = in_last;
      cur_last_d  = 1'b0;
    end else if (load_hold_en) begin
      shreg_d    = hold_q;
      cur_last_d = hold_last_q;
    end else if (load_in_en) begin
      shreg_d    = in_data;
      cur_last_d = in_last;
    end else if (shift_en) begin
      shreg_d = {1'b0, shreg_q[BYTE_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      hold_q      <= '0;
      hold_last_q <= 1'b0;
      cur_last_q  <= 1'b0;
      sent_q      <= 1'b0;
    end else begin
      shreg_q     <= shreg_d;
      hold_q      <= hold_d;
      hold_last_q <= hold_last_d;
      cur_last_q  <= cur_last_d;
      sent_q      <= sent_d;
    end
  end

  assign ser_bit   = shreg_q[0];
  assign cur_last  = cur_last_q;
  assign last_sent = sent_q;

endmodule

// File: rtl/hs_lane_ctrl.sv
`timescale 1ns/1ps
module hs_lane_ctrl
  import hs_lane_pkg::*;
#(
  parameter int LP_HOLD    = 4,
  parameter int TRAIL_BITS = 6,
  parameter int BYTE_W     = LANE_BYTE_W,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_lane_hs,
  input  logic             in_valid,
  input  logic             cnt_done,
  input  logic             cur_last,
  output logic             start,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic [CNT_W-1:0] cnt_limit,
  output logic             load_hold,
  output logic             load_in,
  output logic             shift_en,
  output logic             in_ready,
  output logic [1:0]       lp_drive,
  output logic             hs_en,
  output logic             drive_ser,
  output logic             drive_trail
);

  localparam logic [CNT_W-1:0] LIM_LP    = CNT_W'(LP_HOLD - 1);
  localparam logic [CNT_W-1:0] LIM_BYTE  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LIM_TRAIL = CNT_W'(TRAIL_BITS - 1);

  lane_state_e state_q, state_d;

  // next-state and handshake decode
  always_comb begin
    state_d   = state_q;
    start     = 1'b0;
    load_hold = 1'b0;
    load_in   = 1'b0;
    in_ready  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        in_ready = clk_lane_hs;
        if (clk_lane_hs && in_valid) begin
          start   = 1'b1;
          state_d = ST_LP01;
        end
      end
      ST_LP01: if (cnt_done) state_d = ST_LP00;
      ST_LP00: if (cnt_done) state_d = ST_SYNC;
      ST_SYNC: begin
        if (cnt_done) begin
          load_hold = 1'b1;
          state_d   = ST_DATA;
        end
      end
      ST_DATA: begin
        if (cnt_done) begin
          if (!cur_last) begin
            in_ready = 1'b1;
            if (in_valid) begin
              load_in = 1'b1;
            end else begin
              state_d = ST_TRAIL;
            end
          end else begin
            state_d = ST_TRAIL;
          end
        end
      end
      ST_TRAIL: if (cnt_done) state_d = ST_HOLD;
      ST_HOLD:  if (cnt_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // per-state output and phase length decode
  always_comb begin
    lp_drive    = LINES_BRIDGE;
    hs_en       = 1'b0;
    drive_ser   = 1'b0;
    drive_trail = 1'b0;
    cnt_limit   = '0;
    case (state_q)
      ST_IDLE: begin
        lp_drive = LINES_STOP;
      end
      ST_LP01: begin
        lp_drive  = LINES_REQ;
        cnt_limit = LIM_LP;
      end
      ST_LP00: begin
        cnt_limit = LIM_LP;
      end
      ST_SYNC, ST_DATA: begin
        hs_en     = 1'b1;
        drive_ser = 1'b1;
        cnt_limit = LIM_BYTE;
      end
      ST_TRAIL: begin
        hs_en       = 1'b1;
        drive_trail = 1'b1;
        cnt_limit   = LIM_TRAIL;
      end
      ST_HOLD: begin
        lp_drive  = LINES_STOP;
        cnt_limit = LIM_LP;
      end
      default: begin
        lp_drive = LINES_STOP;
      end
    endcase
  end

  assign shift_en = drive_ser;
  assign cnt_en   = (state_q != ST_IDLE);
  assign cnt_clr  = cnt_done || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/hs_burst_lane_tx.sv
`timescale 1ns/1ps
module hs_burst_lane_tx
  import hs_lane_pkg::*;
#(
  parameter int LP_HOLD    = 4,
  parameter int TRAIL_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clk_lane_hs,
  input  logic                   in_valid,
  input  logic [LANE_BYTE_W-1:0] in_data,
  input  logic                   in_last,
  output logic                   in_ready,
  output logic [1:0]             lp_drive,
  output logic                   hs_en,
  output logic                   hs_bit
);

  localparam int BYTE_W  = LANE_BYTE_W;
  localparam int CNT_TOP = (LP_HOLD > TRAIL_BITS)
                           ? ((LP_HOLD > BYTE_W) ? LP_HOLD : BYTE_W)
                           : ((TRAIL_BITS > BYTE_W) ? TRAIL_BITS : BYTE_W);
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             start, cnt_clr, cnt_en, cnt_done;
  logic [CNT_W-1:0] cnt_limit;
  logic             load_hold, load_in, shift_en;
  logic             drive_ser, drive_trail;
  logic             ser_bit, cur_last, last_sent;

  hs_lane_ctrl #(
    .LP_HOLD   (LP_HOLD),
    .TRAIL_BITS(TRAIL_BITS),
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .clk_lane_hs(clk_lane_hs),
    .in_valid   (in_valid),
    .cnt_done   (cnt_done),
    .cur_last   (cur_last),
    .start      (start),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .cnt_limit  (cnt_limit),
    .load_hold  (load_hold),
    .load_in    (load_in),
    .shift_en   (shift_en),
    .in_ready   (in_ready),
    .lp_drive   (lp_drive),
    .hs_en      (hs_en),
    .drive_ser  (drive_ser),
    .drive_trail(drive_trail)
  );

  hs_lane_phase_cnt #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .clr  (cnt_clr),
    .en   (cnt_en),
    .limit(cnt_limit),
    .done (cnt_done)
  );

  hs_lane_shifter #(
    .BYTE_W(BYTE_W)
  ) shift_i (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .preload_en  (start),
    .load_hold_en(load_hold),
    .load_in_en  (load_in),
    .shift_en    (shift_en),
    .in_data     (in_data),
    .in_last     (in_last),
    .ser_bit     (ser_bit),
    .cur_last    (cur_last),
    .last_sent   (last_sent)
  );

  always_comb begin
    hs_bit = 1'b0;
    if (drive_ser) begin
      hs_bit = ser_bit;
    end else if (drive_trail) begin
      hs_bit = ~last_sent;
    end
  end

endmodule

// File: rtl/hs_lane_checker.sv
`timescale 1ns/1ps
module hs_lane_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_lane_hs,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] lp_drive,
  input logic       hs_en,
  input logic       hs_bit
);

  assert_hs_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |-> !hs_bit);

  assert_lines_low_in_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (lp_drive == 2'b00));

  assert_hs_from_bridge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(lp_drive) == 2'b00));

  assert_req_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_drive) == 2'b11 && lp_drive != 2'b11) |-> (lp_drive == 2'b01));

  assert_bridge_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_drive) == 2'b01 && lp_drive != 2'b01) |-> (lp_drive == 2'b00 && !hs_en));

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_drive) == 2'b11 && lp_drive == 2'b01) |-> $past(clk_lane_hs && in_valid));

  assert_exit_to_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (lp_drive == 2'b11));

  assert_no_ready_preamble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && lp_drive != 2'b11) |-> !in_ready);

endmodule

bind hs_burst_lane_tx hs_lane_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_lane_hs(clk_lane_hs),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lp_drive   (lp_drive),
  .hs_en      (hs_en),
  .hs_bit     (hs_bit)
);

// File: tb/hs_burst_lane_tx_tb_top.sv
`timescale 1ns/1ps
module hs_burst_lane_tx_tb_top;

  localparam int LPH = 3;
  localparam int TRB = 5;
  localparam logic [7:0] SYNC_B = 8'b00011101;

  logic       clk;
  logic       rst_n;
  logic       clk_lane_hs;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic [1:0] lp_drive;
  logic       hs_en;
  logic       hs_bit;

  int n_checks = 0;
  int n_fail   = 0;

  hs_burst_lane_tx #(
    .LP_HOLD   (LPH),
    .TRAIL_BITS(TRB)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_lane_hs(clk_lane_hs),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .lp_drive   (lp_drive),
    .hs_en      (hs_en),
    .hs_bit     (hs_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [1:0] lp;
    logic       hs;
    logic       bt;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push1(input logic [1:0] lp, input logic hs,
                                input logic bt, input logic rdy, input string tag);
    exp_t e;
    e.lp = lp; e.hs = hs; e.bt = bt; e.rdy = rdy; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  // expected per-cycle lane activity from the cycle after acceptance
  function automatic void push_burst(input logic [7:0] b [0:2], input int n,
                                     input bit flag_last);
    for (int i = 0; i < LPH; i++) push1(2'b01, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < LPH; i++) push1(2'b00, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 8; i++)   push1(2'b00, 1'b1, SYNC_B[i], 1'b0, "R4");
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        push1(2'b00, 1'b1, b[k][i],
              (i == 7) && ((k < n - 1) || !flag_last), "R5");
      end
    end
    for (int t = 0; t < TRB; t++) begin
      push1(2'b00, 1'b1, ~b[n-1][7], 1'b0,
            (t == 0) ? (flag_last ? "R7" : "R10") : "R8");
    end
    for (int i = 0; i < LPH; i++) push1(2'b11, 1'b0, 1'b0, 1'b0, "R9");
  endfunction

  // monitor: pops one expected cycle per clock while a burst is tracked
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "lp_drive", {6'd0, lp_drive}, {6'd0, e.lp});
        check(e.tag, "hs_en",    {7'd0, hs_en},    {7'd0, e.hs});
        check(e.tag, "hs_bit",   {7'd0, hs_bit},   {7'd0, e.bt});
        check("R6",  "in_ready", {7'd0, in_ready}, {7'd0, e.rdy});
      end
    end
  end

  // driver: offers bytes, pushes expectation when the first byte is taken
  task automatic send_burst(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input int n, input bit flag_last);
    logic [7:0] b [0:2];
    int idx;
    b[0] = b0; b[1] = b1; b[2] = b2;
    @(negedge clk);
    clk_lane_hs = 1'b1;
    in_valid    = 1'b1;
    in_data     = b[0];
    in_last     = flag_last && (n == 1);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    push_burst(b, n, flag_last);
    idx = 0;
    forever begin
      if (in_ready) begin
        @(negedge clk);
        idx++;
        if (idx == n) begin
          in_valid = 1'b0;
          in_last  = 1'b0;
          break;
        end
        in_data = b[idx];
        in_last = flag_last && (idx == n - 1);
      end else begin
        @(negedge clk);
      end
      #1;
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    clk_lane_hs = 1'b0;
    in_valid    = 1'b0;
    in_data     = 8'h00;
    in_last     = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "lp_drive in reset", {6'd0, lp_drive}, 8'h03);
    check("R1", "hs_en in reset",    {7'd0, hs_en},    8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "lp_drive after reset", {6'd0, lp_drive}, 8'h03);
    check("R1", "hs_en after reset",    {7'd0, hs_en},    8'h00);
    check("R1", "hs_bit after reset",   {7'd0, hs_bit},   8'h00);

    // R2: data offered while the clock lane is not in high-speed mode
    in_valid = 1'b1;
    in_data  = 8'hEE;
    in_last  = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      #1;
      check("R2",  "lp_drive gated",  {6'd0, lp_drive}, 8'h03);
      check("R2",  "in_ready gated",  {7'd0, in_ready}, 8'h00);
      check("R11", "hs_bit while lp", {7'd0, hs_bit},   8'h00);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;

    // single byte, last bit 1 -> trailer of zeros
    send_burst(8'hA5, 8'h00, 8'h00, 1, 1'b1);
    drain();

    // three bytes with all-zero / all-ones neighbours, last bit 0
    send_burst(8'h00, 8'hFF, 8'h3C, 3, 1'b1);
    drain();

    // R10: source runs dry after two bytes without the last flag
    send_burst(8'h81, 8'h7E, 8'h00, 2, 1'b0);
    drain();

    // R9: next burst offered while the previous one is still closing
    send_burst(8'h5A, 8'h00, 8'h00, 1, 1'b1);
    send_burst(8'hC3, 8'h11, 8'h00, 2, 1'b1);
    drain();

    #1;
    check("R2", "in_ready idle with gate", {7'd0, in_ready}, 8'h01);
    check("R9", "lp_drive back at stop",   {6'd0, lp_drive}, 8'h03);
    clk_lane_hs = 1'b0;
    #1;
    check("R2", "in_ready idle no gate",   {7'd0, in_ready}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule